// File: doc/BRIEF.md
# Posted-CAS Read/Write Latency Tracker

This block keeps the data-side timing of a double-data-rate memory controller. Each accepted READ or WRITE column command is turned into a window of clock cycles. During a read window the controller captures returning data. During a write window it drives write data and the data mask. Each clock cycle carries two data beats, one on each edge. The single drive enable per cycle therefore covers the mask on both halves of every beat pair.

Read latency is the sum of a programmable CAS latency (3 to 5 clocks) and a programmable additive latency (0 to 4 clocks). Write latency is always one clock shorter than read latency. A burst of 4 occupies 2 cycles and a burst of 8 occupies 4 cycles. Commands are assumed to be legal and already spaced by the upstream scheduler.

The configuration is owned by a two-state machine:
- ST_IDLE: no window is pending. The active configuration follows the configuration inputs every cycle.
- ST_LOCKED: at least one window is in flight. The configuration is frozen.

There are four transitions:
- ST_IDLE to ST_LOCKED: a command enters the pipeline.
- ST_LOCKED to ST_IDLE: the last pending cycle leaves.
- ST_IDLE stays in ST_IDLE when no command arrives.
- ST_LOCKED stays in ST_LOCKED while entries remain.

Top module: `posted_cas_tracker`

## Requirements
- R1: With cfg_cl in 3..5 and cfg_al in 0..4 (plain binary clock counts), a READ accepted at clock edge 0 raises rd_capture in the cycles after edges RL through RL+B-1. Here RL = cfg_al + cfg_cl.
- R2: A WRITE accepted at edge 0 raises wr_drive in the cycles after edges RL-1 through RL-1+B-1.
- R3: B, the window length in cycles, is 4 when cfg_bl8 is 1 (burst of 8) and 2 when cfg_bl8 is 0 (burst of 4).
- R4: Same-direction commands spaced exactly B cycles apart at the largest latency all produce windows with no gap and no lost entry.
- R5: beat_idx is 0 in the first cycle of every burst window and counts up by one per cycle to B-1. It is 0 outside any window.
- R6: In ST_IDLE, a command uses the configuration inputs present at its own edge.
- R7: Configuration changes made while in ST_LOCKED do not affect commands until the pipeline has drained. After draining, the new values apply.
- R8: overlap_err pulses for one cycle, after the edge of a command whose window overlaps a pending window of the opposite direction. The offending command is still scheduled. Adjacent windows do not flag.
- R9: During and right after reset, rd_capture, wr_drive, overlap_err and beat_idx are all 0.
- R10: No window output is active while the machine is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A column command is accepted at this edge |
| cmd_is_write | input | 1 | 1 = WRITE, 0 = READ |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| rd_capture | output | 1 | Read data arrives this cycle |
| wr_drive | output | 1 | Drive write data and mask this cycle |
| beat_idx | output | 2 | Cycle index inside the current burst |
| overlap_err | output | 1 | Opposite-direction window collision |

## Verification
The bench builds the block with its default parameters: maximum CAS latency 5, maximum additive latency 4, and longest burst 4 cycles. This gives a 13-stage pipeline. These defaults let a burst-of-8 read at read latency 9 reach the deepest stage. They also let back-to-back bursts at that latency fill the whole pipeline. With the same parameters, the bench exercises the shortest write latency of 2 and the deferral of a configuration change requested while entries are in flight.

// File: rtl/ptrk_pkg.sv
`timescale 1ns/1ps
package ptrk_pkg;
    localparam int CFG_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_LOCKED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] cl;
        logic [CFG_W-1:0] al;
        logic             bl8;
    } lat_cfg_t;
endpackage

// File: rtl/ptrk_cfg_ctrl.sv
`timescale 1ns/1ps
module ptrk_cfg_ctrl
    import ptrk_pkg::*;
#(
    parameter int LAT_W         = 4,
    parameter int BC_W          = 3,
    parameter int BURST_CYC_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lat_cfg_t         cfg_in,
    input  logic             busy_next,
    output trk_state_e       state,
    output logic [LAT_W-1:0] rd_lat,
    output logic [LAT_W-1:0] wr_lat,
    output logic [BC_W-1:0]  bcyc
);
    trk_state_e state_q, state_d;
    lat_cfg_t   cfg_q, eff;

    // state register and frozen configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= eff;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        eff     = cfg_q;
        unique case (state_q)
            ST_IDLE: begin
                eff     = cfg_in;
                state_d = busy_next ? ST_LOCKED : ST_IDLE;
            end
            ST_LOCKED: begin
                eff     = cfg_q;
                state_d = busy_next ? ST_LOCKED : ST_IDLE;
            end
            default: begin
                eff     = cfg_q;
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state  = state_q;
    assign rd_lat = LAT_W'(eff.cl) + LAT_W'(eff.al);
    assign wr_lat = rd_lat - LAT_W'(1);
    assign bcyc   = eff.bl8 ? BC_W'(BURST_CYC_MAX) : BC_W'(BURST_CYC_MAX / 2);

    // R7: a locked machine keeps its frozen values on the next edge
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/ptrk_pipe.sv
`timescale 1ns/1ps
module ptrk_pipe #(
    parameter int DEPTH = 13,
    parameter int LAT_W = 4,
    parameter int BC_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic [BC_W-1:0]  bcyc,
    output logic [DEPTH-1:0] mask,
    output logic [DEPTH-1:0] occ_q,
    output logic [DEPTH-1:0] occ_d,
    output logic             first_d,
    output logic             active,
    output logic             first
);
    logic [DEPTH-1:0] st_q, st_d;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mask[i] = (i >= int'(lat)) && (i < int'(lat) + int'(bcyc));
        end
    end

    always_comb begin
        occ_d = (occ_q >> 1) | (load ? mask : '0);
        st_d  = st_q >> 1;
        for (int i = 0; i < DEPTH; i++) begin
            if (load && (i == int'(lat))) st_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            st_q  <= '0;
        end else begin
            occ_q <= occ_d;
            st_q  <= st_d;
        end
    end

    assign first_d = st_d[0];
    assign active  = occ_q[0];
    assign first   = st_q[0];

    // R5: a burst start marker only lands inside an active window
    a_r5_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        first |-> active);
endmodule

// File: rtl/ptrk_beat.sv
`timescale 1ns/1ps
module ptrk_beat #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_d,
    input  logic              first_d,
    output logic [BEAT_W-1:0] beat
);
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (first_d) beat_q <= '0;
        else if (act_d)   beat_q <= beat_q + BEAT_W'(1);
        else              beat_q <= '0;
    end

    assign beat = beat_q;
endmodule

// File: rtl/posted_cas_tracker.sv
`timescale 1ns/1ps
module posted_cas_tracker
    import ptrk_pkg::*;
#(
    parameter int CL_MAX        = 5,
    parameter int AL_MAX        = 4,
    parameter int BURST_CYC_MAX = 4,
    parameter int BEAT_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_write,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_al,
    input  logic              cfg_bl8,
    output logic              rd_capture,
    output logic              wr_drive,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              overlap_err
);
    localparam int DEPTH = CL_MAX + AL_MAX + BURST_CYC_MAX;
    localparam int LAT_W = $clog2(DEPTH + 1);
    localparam int BC_W  = $clog2(BURST_CYC_MAX + 1);

    trk_state_e       state;
    lat_cfg_t         cfg_in;
    logic [LAT_W-1:0] rd_lat, wr_lat;
    logic [BC_W-1:0]  bcyc;
    logic             rd_load, wr_load, busy_next, err_d, err_q;
    logic [DEPTH-1:0] rd_mask, rd_occ_q, rd_occ_d;
    logic [DEPTH-1:0] wr_mask, wr_occ_q, wr_occ_d;
    logic             rd_first_d, wr_first_d, rd_act, wr_act, rd_first, wr_first;

    assign cfg_in    = '{cl: cfg_cl, al: cfg_al, bl8: cfg_bl8};
    assign rd_load   = cmd_valid && !cmd_is_write;
    assign wr_load   = cmd_valid && cmd_is_write;
    assign busy_next = |(rd_occ_d | wr_occ_d);

    ptrk_cfg_ctrl #(.LAT_W(LAT_W), .BC_W(BC_W), .BURST_CYC_MAX(BURST_CYC_MAX)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .busy_next(busy_next),
        .state(state), .rd_lat(rd_lat), .wr_lat(wr_lat), .bcyc(bcyc)
    );

    ptrk_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W), .BC_W(BC_W)) u_rd_pipe (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .lat(rd_lat), .bcyc(bcyc),
        .mask(rd_mask), .occ_q(rd_occ_q), .occ_d(rd_occ_d),
        .first_d(rd_first_d), .active(rd_act), .first(rd_first)
    );

    ptrk_pipe #(.DEPTH(DEPTH), .LAT_W(LAT_W), .BC_W(BC_W)) u_wr_pipe (
        .clk(clk), .rst_n(rst_n), .load(wr_load), .lat(wr_lat), .bcyc(bcyc),
        .mask(wr_mask), .occ_q(wr_occ_q), .occ_d(wr_occ_d),
        .first_d(wr_first_d), .active(wr_act), .first(wr_first)
    );

    ptrk_beat #(.BEAT_W(BEAT_W)) u_beat (
        .clk(clk), .rst_n(rst_n),
        .act_d(rd_occ_d[0] || wr_occ_d[0]),
        .first_d(rd_first_d || wr_first_d),
        .beat(beat_idx)
    );

    // collision of a new window with pending opposite-direction cycles
    always_comb begin
        err_d = 1'b0;
        if (rd_load) err_d = |(rd_mask & (wr_occ_q >> 1));
        if (wr_load) err_d = |(wr_mask & (rd_occ_q >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign rd_capture  = rd_act;
    assign wr_drive    = wr_act;
    assign overlap_err = err_q;

    // R10: nothing is driven or captured while the machine is idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!rd_capture && !wr_drive));

    // R8: an error pulse always follows an accepted command
    a_r8_err_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |-> $past(cmd_valid));

    // R5: the beat index rests at zero outside windows
    a_r5_beat_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_capture || wr_drive) |-> (beat_idx == '0));

    // R5: a read window opening on its own begins at beat zero
    a_r5_beat_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_capture) && !wr_drive) |-> (beat_idx == '0));

    // R9: outputs are clear on the first cycle after reset
    a_r9_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> (!rd_capture && !wr_drive && !overlap_err));
endmodule

// File: tb/test_posted_cas_tracker.sv
`timescale 1ns/1ps
module test_posted_cas_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_is_write = 1'b0;
    logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
    logic       cfg_bl8 = 1'b0;
    logic       rd_capture, wr_drive, overlap_err;
    logic [1:0] beat_idx;

    int  total = 0, bad = 0;
    bit  done = 0;

    logic [31:0] sv, sw, rd_rec, wr_rec, err_rec;
    int          swap_at;
    logic [2:0]  sw_cl, sw_al;
    logic        sw_b;
    int          beat_rec[32];

    always #2.5 clk = ~clk;

    posted_cas_tracker i_posted_cas_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
        .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
        .rd_capture(rd_capture), .wr_drive(wr_drive),
        .beat_idx(beat_idx), .overlap_err(overlap_err)
    );

    function automatic logic [31:0] win(input int s, input int n);
        logic [31:0] v = '0;
        for (int i = s; i < s + n; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // runs 32 cycles from a negedge; sample j is taken after edge j
    task automatic run_seq();
        for (int j = 0; j < 32; j++) begin
            if (j == swap_at) begin
                cfg_cl = sw_cl; cfg_al = sw_al; cfg_bl8 = sw_b;
            end
            cmd_valid = sv[j];
            cmd_is_write = sw[j];
            @(posedge clk);
            @(negedge clk);
            rd_rec[j] = rd_capture;
            wr_rec[j] = wr_drive;
            err_rec[j] = overlap_err;
            beat_rec[j] = int'(beat_idx);
        end
        cmd_valid = 1'b0;
        cmd_is_write = 1'b0;
    endtask

    task automatic set_cfg(input int cl, input int al, input bit b8);
        cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = b8;
        swap_at = -1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!rd_capture && !wr_drive && !overlap_err && beat_idx == 0,
            "R9 outputs in reset", {rd_capture, wr_drive, overlap_err, beat_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_capture && !wr_drive && !overlap_err && beat_idx == 0,
            "R9 outputs after reset", {rd_capture, wr_drive, overlap_err, beat_idx}, 0);
    endtask

    task automatic t_single(input bit wr, input int cl, input int al, input bit b8);
        int l = cl + al - (wr ? 1 : 0);
        int b = b8 ? 4 : 2;
        set_cfg(cl, al, b8);
        sv = 32'h1; sw = wr ? 32'h1 : 32'h0;
        run_seq();
        if (wr) begin
            chk(wr_rec == win(l, b), "R2 R3 write window", wr_rec, win(l, b));
            chk(rd_rec == 0, "R10 no read window for write", rd_rec, 0);
        end else begin
            chk(rd_rec == win(l, b), "R1 R3 read window", rd_rec, win(l, b));
            chk(wr_rec == 0, "R10 no write window for read", wr_rec, 0);
        end
        chk(beat_rec[l] == 0 && beat_rec[l + b - 1] == b - 1, "R5 beat first/last",
            beat_rec[l + b - 1], b - 1);
        chk(beat_rec[l + b] == 0, "R5 beat rests after window", beat_rec[l + b], 0);
    endtask

    task automatic t_back_to_back();
        bit ok = 1;
        set_cfg(5, 4, 1);
        sv = 32'h111; sw = 32'h0;
        run_seq();
        chk(rd_rec == win(9, 12), "R4 back-to-back read windows", rd_rec, win(9, 12));
        for (int k = 0; k < 12; k++) if (beat_rec[9 + k] != k % 4) ok = 0;
        chk(ok, "R4 R5 beat sequence over merged bursts", beat_rec[13], 0);
    endtask

    task automatic t_idle_sample();
        set_cfg(3, 0, 0);
        swap_at = 0; sw_cl = 3'd4; sw_al = 3'd2; sw_b = 1'b0;
        sv = 32'h1; sw = 32'h0;
        run_seq();
        chk(rd_rec == win(6, 2), "R6 idle command uses inputs at its edge", rd_rec, win(6, 2));
    endtask

    task automatic t_defer();
        set_cfg(3, 0, 0);
        swap_at = 1; sw_cl = 3'd5; sw_al = 3'd4; sw_b = 1'b1;
        sv = 32'h5; sw = 32'h0;
        run_seq();
        chk(rd_rec == win(3, 4), "R7 change deferred while busy", rd_rec, win(3, 4));
        swap_at = -1;
        sv = 32'h1;
        run_seq();
        chk(rd_rec == win(9, 4), "R7 new values after drain", rd_rec, win(9, 4));
    endtask

    task automatic t_overlap();
        set_cfg(3, 0, 0);
        sv = 32'h3; sw = 32'h2;
        run_seq();
        chk(err_rec == 32'h2, "R8 overlap pulse", err_rec, 32'h2);
        chk(wr_rec == win(3, 2), "R8 colliding write still scheduled", wr_rec, win(3, 2));
        set_cfg(3, 0, 0);
        sv = 32'h9; sw = 32'h8;
        run_seq();
        chk(err_rec == 0, "R8 adjacent windows do not flag", err_rec, 0);
        chk(wr_rec == win(5, 2) && rd_rec == win(3, 2), "R8 adjacent windows placed",
            wr_rec, win(5, 2));
    endtask

    initial begin
        swap_at = -1;
        t_reset();
        t_single(1'b0, 3, 0, 1'b0);
        t_single(1'b0, 5, 4, 1'b1);
        t_single(1'b0, 4, 2, 1'b0);
        t_single(1'b1, 3, 0, 1'b0);
        t_single(1'b1, 5, 4, 1'b1);
        t_single(1'b1, 4, 1, 1'b1);
        t_back_to_back();
        t_idle_sample();
        t_defer();
        t_overlap();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule